// File: doc/BRIEF.md
# Burst-of-Two ECC Memory Core

This block is a synchronous word store with an independent write port and read port that may both be used in the same cycle. Each port moves data in beats half as wide as the internal word. A write command brings its address and the lower beat in one cycle and the upper beat in the next. The two beats are joined and committed to the array in one operation. A read command fetches one full word, runs single-error correction on it and returns the lower half and then the upper half on consecutive cycles. One address therefore selects a full double-width word, so the address is one bit narrower than a beat-granular depth would need.

Every beat has per-byte lane enables. When a write enables every lane of both beats, check bits are computed over the full word and stored with it. A write that enables only some lanes (a half-word write is the usual case) cannot recompute them. Such a write marks the word as unprotected, and reads of that word then return the stored bits without correction. A read that overlaps a write still in flight at the same address returns the new data. A fault-injection input lets single stored bits be flipped on purpose so that the correction path can be exercised.

Top module: `dual_beat_ecc_ram`

## Requirements
- R1: After reset every word reads as zero, `rd_valid` is low, and `rd_corrected` is low.
- R2: A write command taken in cycle T supplies the address, the lower beat (word bits [15:0]) and its lane enables. Cycle T+1 supplies the upper beat (bits [31:16]) and its enables, and the word is committed at the end of T+1. `wr_en` raised in cycle T+1 is ignored.
- R3: A read command taken in cycle C gives `rd_valid` high with the lower half in C+2 and the upper half in C+3. `rd_valid` is low in C+1. `rd_en` raised in C+1 is ignored.
- R4: Bit i of `wr_be` enables byte i of its beat (bits [8i+7:8i] of that beat). Bytes that are not enabled keep their old contents. A write with no lane enabled in either beat leaves the word, including its protection state, unchanged.
- R5: A write with all four lanes enabled stores check bits computed before `wr_flip` is XORed into the stored data. On read, any single flipped data bit is corrected, and `rd_corrected` is high only in the lower-beat cycle.
- R6: A write with some but not all lanes enabled marks the word unprotected. Reads of such a word return the stored bits (flips included) with `rd_corrected` low, and a later full write restores protection.
- R7: A read issued in the write-command cycle or the upper-beat cycle of a write to the same address returns the new word. A read issued the cycle before the write command returns the old word.
- R8: A read of a protected word with no flipped bit returns the written data with `rd_corrected` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all activity on rising edges |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write command, carries the lower beat |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 16 | Write beat data |
| wr_be | input | 2 | Byte lane enables of the current write beat |
| wr_flip | input | 32 | Fault mask XORed into stored data, sampled in the upper-beat cycle |
| rd_en | input | 1 | Read command |
| rd_addr | input | 4 | Word address of the read |
| rd_data | output | 16 | Read beat data |
| rd_valid | output | 1 | Read beat present on `rd_data` |
| rd_corrected | output | 1 | A single-bit error was corrected in the word now being returned |

## Verification
A write command becomes visible to a normal read once its upper beat has been taken, one cycle after the command. Each read's lower beat is due two cycles after `rd_en` and its upper beat three cycles after. The bench drives inputs on falling edges and samples outputs on the second and third falling edges after a read command, where both beats and the correction flag are checked. It also checks that `rd_valid` is low on the first falling edge, and on the fourth after a read whose follow-up command must be ignored. The forwarding cases launch the read on the falling edge of the cycle before, during or after the write command, so the expected word is decided by which of those cycles the read falls in.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
    localparam int BEAT_W     = 16;
    localparam int ADDR_W     = 4;
    localparam int WORD_W     = 2 * BEAT_W;
    localparam int LANES_BEAT = BEAT_W / 8;
    localparam int LANES      = 2 * LANES_BEAT;
    localparam int DEPTH      = 1 << ADDR_W;

    function automatic int chk_width(int d);
        for (int r = 2; r < 32; r++) begin
            if ((1 << r) >= d + r + 1) return r;
        end
        return 32;
    endfunction

    localparam int CHK_W = chk_width(WORD_W);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CHK_W-1:0]  chk_t;
    typedef logic [LANES-1:0]  lanes_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        word_t data;
        chk_t  chk;
        logic  raw;
    } entry_t;

    typedef struct packed {
        logic   vld;
        addr_t  addr;
        word_t  data;
        chk_t   chk;
        lanes_t be;
    } commit_t;

    // Codeword position of data bit idx; powers of two are left to check bits.
    function automatic int code_pos(int idx);
        int seen = 0;
        for (int p = 3; p < 4 * WORD_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (seen == idx) return p;
                seen++;
            end
        end
        return 0;
    endfunction

    function automatic chk_t ecc_encode(word_t d);
        chk_t c = '0;
        for (int i = 0; i < WORD_W; i++) begin
            for (int j = 0; j < CHK_W; j++) begin
                if (((code_pos(i) >> j) & 1) == 1) c[j] = c[j] ^ d[i];
            end
        end
        return c;
    endfunction

    function automatic word_t ecc_correct(word_t d, chk_t syn);
        word_t f = d;
        for (int i = 0; i < WORD_W; i++) begin
            if (code_pos(i) == int'(syn)) f[i] = ~f[i];
        end
        return f;
    endfunction

    function automatic entry_t merge_entry(entry_t old, commit_t c);
        entry_t n = old;
        if (c.be != '0) begin
            for (int l = 0; l < LANES; l++) begin
                if (c.be[l]) n.data[8*l +: 8] = c.data[8*l +: 8];
            end
            if (&c.be) begin
                n.chk = c.chk;
                n.raw = 1'b0;
            end else begin
                n.raw = 1'b1;
            end
        end
        return n;
    endfunction
endpackage

// File: rtl/dbr_wr_gather.sv
module dbr_wr_gather
    import dbr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  addr_t                 wr_addr,
    input  logic [BEAT_W-1:0]     wr_data,
    input  logic [LANES_BEAT-1:0] wr_be,
    input  word_t                 wr_flip,
    output commit_t               commit
);
    logic                  pend_q;
    addr_t                 addr_q;
    logic [BEAT_W-1:0]     lo_q;
    logic [LANES_BEAT-1:0] be_lo_q;
    word_t                 clean;
    logic                  take;

    assign take = wr_en && !pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= 1'b0;
            addr_q  <= '0;
            lo_q    <= '0;
            be_lo_q <= '0;
        end else begin
            pend_q <= take;
            if (take) begin
                addr_q  <= wr_addr;
                lo_q    <= wr_data;
                be_lo_q <= wr_be;
            end
        end
    end

    always_comb begin
        clean       = {wr_data, lo_q};
        commit.vld  = pend_q;
        commit.addr = addr_q;
        commit.data = clean ^ wr_flip;
        commit.chk  = ecc_encode(clean);
        commit.be   = {wr_be, be_lo_q};
    end

    AST_WR_BEAT_SLOT: assert property (@(posedge clk) disable iff (rst)
        pend_q |=> !pend_q); // R2
endmodule

// File: rtl/dbr_array.sv
module dbr_array
    import dbr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  commit_t commit,
    input  addr_t   rd_addr,
    output entry_t  rd_entry
);
    entry_t mem_q [DEPTH];
    entry_t wr_next;

    always_comb wr_next = merge_entry(mem_q[commit.addr], commit);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (commit.vld) begin
            mem_q[commit.addr] <= wr_next;
        end
    end

    // A write committing in this cycle is forwarded to the read lookup.
    always_comb begin
        if (commit.vld && commit.addr == rd_addr) rd_entry = wr_next;
        else                                      rd_entry = mem_q[rd_addr];
    end

    AST_FULL_WR_PROTECTED: assert property (@(posedge clk) disable iff (rst)
        commit.vld && (&commit.be) |=> !mem_q[$past(commit.addr)].raw); // R5
    AST_PART_WR_RAW: assert property (@(posedge clk) disable iff (rst)
        commit.vld && commit.be != '0 && !(&commit.be) |=> mem_q[$past(commit.addr)].raw); // R6
endmodule

// File: rtl/dbr_rd_pipe.sv
module dbr_rd_pipe
    import dbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  addr_t             rd_addr,
    output addr_t             arr_addr,
    input  entry_t            arr_entry,
    output logic [BEAT_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_corrected
);
    logic  s1_q;
    addr_t a1_q;
    word_t word_q;
    logic  corr_q, vld_q, hi_q;
    chk_t  syn;
    word_t fixed;
    logic  flag;

    always_comb begin
        syn   = arr_entry.chk ^ ecc_encode(arr_entry.data);
        fixed = arr_entry.data;
        flag  = 1'b0;
        if (!arr_entry.raw) begin
            fixed = ecc_correct(arr_entry.data, syn);
            flag  = (syn != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b0;
            a1_q   <= '0;
            word_q <= '0;
            corr_q <= 1'b0;
            vld_q  <= 1'b0;
            hi_q   <= 1'b0;
        end else begin
            s1_q <= rd_en && !s1_q;
            if (rd_en && !s1_q) a1_q <= rd_addr;
            if (s1_q) begin
                word_q <= fixed;
                corr_q <= flag;
                vld_q  <= 1'b1;
                hi_q   <= 1'b0;
            end else if (vld_q && !hi_q) begin
                hi_q <= 1'b1;
            end else begin
                vld_q <= 1'b0;
                hi_q  <= 1'b0;
            end
        end
    end

    assign arr_addr     = a1_q;
    assign rd_data      = hi_q ? word_q[WORD_W-1:BEAT_W] : word_q[BEAT_W-1:0];
    assign rd_valid     = vld_q;
    assign rd_corrected = vld_q && !hi_q && corr_q;

    AST_RD_ONE_SLOT: assert property (@(posedge clk) disable iff (rst)
        s1_q |=> !s1_q); // R3
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        s1_q |=> rd_valid && !hi_q); // R3
    AST_RD_BEAT_PAIR: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !hi_q |=> rd_valid && hi_q); // R3
    AST_RAW_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        s1_q && arr_entry.raw |=> !rd_corrected); // R6
    AST_CORR_ONE_BEAT: assert property (@(posedge clk) disable iff (rst)
        rd_corrected |=> !rd_corrected); // R5
endmodule

// File: rtl/dual_beat_ecc_ram.sv
module dual_beat_ecc_ram
    import dbr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [BEAT_W-1:0]     wr_data,
    input  logic [LANES_BEAT-1:0] wr_be,
    input  logic [WORD_W-1:0]     wr_flip,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [BEAT_W-1:0]     rd_data,
    output logic                  rd_valid,
    output logic                  rd_corrected
);
    commit_t commit;
    addr_t   arr_addr;
    entry_t  arr_entry;

    dbr_wr_gather u_gather (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_be   (wr_be),
        .wr_flip (wr_flip),
        .commit  (commit)
    );

    dbr_array u_array (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .rd_addr  (arr_addr),
        .rd_entry (arr_entry)
    );

    dbr_rd_pipe u_rd (
        .clk          (clk),
        .rst          (rst),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .arr_addr     (arr_addr),
        .arr_entry    (arr_entry),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .rd_corrected (rd_corrected)
    );
endmodule

// File: tb/test_dual_beat_ecc_ram.sv
module test_dual_beat_ecc_ram;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  wr_be = '0;
    logic [31:0] wr_flip = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        rd_corrected;

    int checks = 0;
    int fails  = 0;

    logic [31:0] m_phys  [16];
    logic [31:0] m_clean [16];
    logic        m_raw   [16];

    always #10 clk = ~clk;

    dual_beat_ecc_ram i_dual_beat_ecc_ram (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .wr_flip(wr_flip),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_valid(rd_valid), .rd_corrected(rd_corrected)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(int a);
        return m_raw[a] ? m_phys[a] : m_clean[a];
    endfunction

    function automatic logic exp_corr(int a);
        return !m_raw[a] && (m_phys[a] != m_clean[a]);
    endfunction

    task automatic model_wr(int a, logic [31:0] w, logic [3:0] be, logic [31:0] flip);
        for (int l = 0; l < 4; l++)
            if (be[l]) m_phys[a][8*l +: 8] = w[8*l +: 8] ^ flip[8*l +: 8];
        if (be == 4'hF) begin
            m_clean[a] = w;
            m_raw[a]   = 1'b0;
        end else if (be != 4'h0) begin
            m_raw[a] = 1'b1;
        end
    endtask

    task automatic do_write(int a, logic [31:0] w, logic [3:0] be, logic [31:0] flip);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = w[15:0]; wr_be = be[1:0];
        @(negedge clk);
        wr_en = 1'b0; wr_data = w[31:16]; wr_be = be[3:2]; wr_flip = flip;
        model_wr(a, w, be, flip);
        @(negedge clk);
        wr_data = '0; wr_be = '0; wr_flip = '0;
    endtask

    task automatic do_read(int a, string req);
        logic [31:0] ew;
        logic        ec;
        ew = exp_word(a);
        ec = exp_corr(a);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 4'(a);
        @(negedge clk);
        rd_en = 1'b0;
        check({req, " R3 idle in C+1"}, 32'(rd_valid), 32'd0);
        @(negedge clk);
        check({req, " R3 valid lower"}, 32'(rd_valid), 32'd1);
        check({req, " lower data"}, 32'(rd_data), 32'(ew[15:0]));
        check({req, " corrected flag lower"}, 32'(rd_corrected), 32'(ec));
        @(negedge clk);
        check({req, " R3 valid upper"}, 32'(rd_valid), 32'd1);
        check({req, " upper data"}, 32'(rd_data), 32'(ew[31:16]));
        check({req, " R5 flag low on upper"}, 32'(rd_corrected), 32'd0);
    endtask

    task automatic t_reset();
        check("R1 rd_valid after reset", 32'(rd_valid), 32'd0);
        check("R1 rd_corrected after reset", 32'(rd_corrected), 32'd0);
        do_read(3, "R1 word 3");
        do_read(15, "R1 word 15");
    endtask

    task automatic t_full_rw();
        do_write(1, 32'h1234_5678, 4'hF, '0);
        do_write(6, 32'hFFFF_0000, 4'hF, '0);
        do_write(15, 32'hA5C3_3C5A, 4'hF, '0);
        do_read(1, "R2 R8 word 1");
        do_read(6, "R2 R8 word 6");
        do_read(15, "R2 R8 word 15");
    endtask

    task automatic t_ignore();
        // second wr_en in the upper-beat cycle targets word 3 and must be dropped
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd2; wr_data = 16'h2222; wr_be = 2'b11;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd3; wr_data = 16'h3333; wr_be = 2'b11;
        model_wr(2, 32'h3333_2222, 4'hF, '0);
        @(negedge clk);
        wr_en = 1'b0; wr_data = 16'h4444; wr_be = 2'b11;
        @(negedge clk);
        wr_data = '0; wr_be = '0;
        do_read(3, "R2 ignored write");
        do_read(2, "R2 accepted write");
        // rd_en in the cycle after an accepted read must be dropped
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 4'd2;
        @(negedge clk);
        rd_addr = 4'd1;
        @(negedge clk);
        rd_en = 1'b0;
        check("R3 first read lower", 32'(rd_data), 32'h2222);
        @(negedge clk);
        check("R3 first read upper", 32'(rd_data), 32'h3333);
        @(negedge clk);
        check("R3 ignored read gives no beat", 32'(rd_valid), 32'd0);
    endtask

    task automatic t_lanes();
        do_write(4, 32'h4433_2211, 4'hF, '0);
        do_write(4, 32'hDDCC_BBAA, 4'b1001, '0);
        do_read(4, "R4 lanes 0 and 3");
        do_write(5, 32'h5555_5555, 4'hF, '0);
        do_write(5, 32'h0000_0000, 4'h0, 32'h0000_0001);
        do_read(5, "R4 no lane enabled");
    endtask

    task automatic t_correct();
        do_write(7, 32'hCAFE_F00D, 4'hF, 32'h0000_0001);
        do_read(7, "R5 flip bit 0");
        do_write(8, 32'h0BAD_BEEF, 4'hF, 32'h8000_0000);
        do_read(8, "R5 flip bit 31");
        do_write(10, 32'h1357_9BDF, 4'hF, 32'h0002_0000);
        do_read(10, "R5 flip bit 17");
    endtask

    task automatic t_half();
        do_write(11, 32'h7777_8888, 4'hF, '0);
        do_write(11, 32'h0000_1234, 4'b0011, 32'h0000_0010);
        do_read(11, "R6 half write raw");
        do_write(11, 32'h6666_9999, 4'hF, 32'h0100_0000);
        do_read(11, "R6 full write restores");
    endtask

    task automatic t_coherent();
        logic [31:0] old_w;
        do_write(9, 32'hAAAA_5555, 4'hF, '0);
        // read one cycle before the write command: old word
        old_w = exp_word(9);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 4'd9;
        @(negedge clk);
        rd_en = 1'b0;
        wr_en = 1'b1; wr_addr = 4'd9; wr_data = 16'h1111; wr_be = 2'b11;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 16'h2222;
        model_wr(9, 32'h2222_1111, 4'hF, '0);
        check("R7 early read lower old", 32'(rd_data), 32'(old_w[15:0]));
        @(negedge clk);
        wr_data = '0; wr_be = '0;
        check("R7 early read upper old", 32'(rd_data), 32'(old_w[31:16]));
        // read in the write command cycle: forwarded, flipped bit corrected
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 4'd9;
        wr_en = 1'b1; wr_addr = 4'd9; wr_data = 16'h3C3C; wr_be = 2'b11;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0; wr_data = 16'h4B4B; wr_flip = 32'h0000_0400;
        model_wr(9, 32'h4B4B_3C3C, 4'hF, 32'h0000_0400);
        @(negedge clk);
        wr_data = '0; wr_be = '0; wr_flip = '0;
        check("R7 same-cycle read lower new", 32'(rd_data), 32'h3C3C);
        check("R7 R5 forwarded word corrected", 32'(rd_corrected), 32'd1);
        @(negedge clk);
        check("R7 same-cycle read upper new", 32'(rd_data), 32'h4B4B);
        // read in the upper-beat cycle: forwarded
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd9; wr_data = 16'h9876; wr_be = 2'b11;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 16'h5432; rd_en = 1'b1; rd_addr = 4'd9;
        model_wr(9, 32'h5432_9876, 4'hF, '0);
        @(negedge clk);
        rd_en = 1'b0; wr_data = '0; wr_be = '0;
        @(negedge clk);
        check("R7 beat-1 read lower new", 32'(rd_data), 32'h9876);
        @(negedge clk);
        check("R7 beat-1 read upper new", 32'(rd_data), 32'h5432);
        do_read(9, "R7 word after commit");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_phys[i] = '0; m_clean[i] = '0; m_raw[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full_rw();
        t_ignore();
        t_lanes();
        t_correct();
        t_half();
        t_coherent();
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule